// File: doc/BRIEF.md
# Rule-Driven Link and Activity LED Controller

This block drives a small set of indicator outputs from the state of an Ethernet link and from per-packet activity pulses. Each output has two rule words. A lit-rule word selects the link states that keep the LED steadily on. A flash-rule word selects the activity events that make it blink. The lit-rule word also holds an enable bit, a polarity bit and a force-on bit, and the flash-rule word holds a force-flash bit. A shared control word gates every output. A shared on-time word and a shared period word set the blink waveform, counted in ticks of an internal prescaler.

The link logic sits outside the block and supplies link-up, a 2-bit speed code, duplex, and single-cycle pulses for transmit, receive, collision, CRC error and idle error. Software programs the rule words through a simple write strobe with an address. Any word can be read back at once on a combinational read port. Each LED output is registered and changes one clock after the state that decides it.

Top module: `led_ctrl`

## Requirements
- R1: Word map: control at 0x21 (keeps bits 15, 3, 2, 1:0), on-time at 0x22 (16 bits), period at 0x23 (16 bits), lit-rule of LED i at 0x24+2i (keeps bits 15, 14, 8, 6:0), flash-rule of LED i at 0x25+2i (keeps bits 11:0). Bits that are not kept read as zero. Any other address reads zero, and a write to it changes nothing.
- R2: After reset every word reads zero and every LED output is 1, which is the inactive level under polarity 0.
- R3: An LED output is lit only while control bit 15 (external drive) and control bit 3 (clock run) are both 1. Otherwise every output sits at its inactive level and all blink state is cleared.
- R4: Lit-rule bit 15 enables the LED. A disabled LED drives its inactive level. Lit-rule bit 14 sets polarity: 1 drives 1 when lit, and 0 inverts the output. The output updates one clock after its inputs.
- R5: With the link up, speed code 0=10, 1=100, 2=1000 and 3=2500 lights the LED when lit-rule bit 2, 1, 0 or 8 is set, in that order.
- R6: Lit-rule bit 4 lights the LED on an up link at full duplex, bit 5 on an up link at half duplex, and bit 3 while the link is down.
- R7: Lit-rule bit 6 lights an enabled LED whatever the link state.
- R8: With the link up, a transmit or receive pulse is a flash event when the flash-rule bit for the current speed is set: TX/RX on bits 4/5 at speed 10, bits 2/3 at 100, bits 0/1 at 1000 and bits 10/11 at 2500. A collision pulse matches bit 6, a CRC error bit 7 and an idle error bit 8. Nothing is an event while the link is down.
- R9: On the first tick after an event, a blink cycle starts. The LED is lit while the tick count within the cycle is below the on-time. At the tick that completes the period, the cycle restarts if an event was seen during the cycle or force-flash is set, and otherwise it stops. A period of 0 or 1 ends every cycle after one tick.
- R10: Flash-rule bit 9 blinks the LED without stopping for as long as it is set.
- R11: While control bit 3 is 1, one tick occurs every TICK_DIV clocks. When bit 3 is cleared, the prescaler restarts from zero.
- R12: Control bits 2:0 are stored and read back, and have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for reg_addr/reg_wdata |
| reg_addr | input | ADDR_W | Word address for write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data of reg_addr |
| link_up | input | 1 | Link is up |
| link_speed | input | 2 | Speed code: 0=10, 1=100, 2=1000, 3=2500 |
| link_fdx | input | 1 | Full duplex when 1 |
| tx_pkt | input | 1 | Transmit activity pulse |
| rx_pkt | input | 1 | Receive activity pulse |
| col_evt | input | 1 | Collision pulse |
| crc_err | input | 1 | Receive CRC error pulse |
| idle_err | input | 1 | Receive idle error pulse |
| led_out | output | N_LED | LED drive levels |

## Verification
The hardest behaviour to reach from the ports is blink re-arming. The outcome depends on whether an activity pulse lands before a tick, inside a running cycle, or on the tick that closes the period, and the prescaler hides where those ticks fall. The stimulus therefore uses a single isolated pulse to measure the lit length of one cycle, then sends a train of pulses spaced closer than a period to force repeated restarts. It also sets a period of zero to test the degenerate wrap. A behavioural model in the bench tracks the tick phase and is compared on every clock, so every placement of a pulse against a tick is checked.

// File: rtl/led_pkg.sv
package led_pkg;

  localparam int WORD_W = 16;

  localparam int A_CTRL   = 'h21;
  localparam int A_ONTIME = 'h22;
  localparam int A_PERIOD = 'h23;
  localparam int A_RULE0  = 'h24;

  localparam logic [WORD_W-1:0] KEEP_CTRL  = 16'h800F;
  localparam logic [WORD_W-1:0] KEEP_LIT   = 16'hC17F;
  localparam logic [WORD_W-1:0] KEEP_FLASH = 16'h0FFF;

  localparam int C_EXT = 15;
  localparam int C_RUN = 3;

  localparam int L_G1000 = 0;
  localparam int L_M100  = 1;
  localparam int L_M10   = 2;
  localparam int L_DOWN  = 3;
  localparam int L_FULL  = 4;
  localparam int L_HALF  = 5;
  localparam int L_FORCE = 6;
  localparam int L_G2500 = 8;
  localparam int L_POL   = 14;
  localparam int L_EN    = 15;

  localparam int F_FORCE = 9;

  typedef enum logic [1:0] {
    SPD_10   = 2'd0,
    SPD_100  = 2'd1,
    SPD_1000 = 2'd2,
    SPD_2500 = 2'd3
  } speed_e;

  typedef struct packed {
    logic   up;
    speed_e spd;
    logic   fdx;
  } link_t;

  typedef struct packed {
    logic tx;
    logic rx;
    logic col;
    logic crc;
    logic idle;
  } act_t;

  // Steady-lit match of a lit-rule word against the link state.
  function automatic logic lit_match(input logic [WORD_W-1:0] r, input link_t lk);
    logic h;
    if (!lk.up) begin
      h = r[L_DOWN];
    end else begin
      h = (r[L_FULL] & lk.fdx) | (r[L_HALF] & ~lk.fdx);
      case (lk.spd)
        SPD_10:   h = h | r[L_M10];
        SPD_100:  h = h | r[L_M100];
        SPD_1000: h = h | r[L_G1000];
        SPD_2500: h = h | r[L_G2500];
      endcase
    end
    return h;
  endfunction

  // Flash event match of a flash-rule word against this cycle's pulses.
  function automatic logic flash_match(input logic [WORD_W-1:0] r, input link_t lk,
                                       input act_t a);
    logic h;
    h = (a.col & r[6]) | (a.crc & r[7]) | (a.idle & r[8]);
    case (lk.spd)
      SPD_10:   h = h | (a.tx & r[4])  | (a.rx & r[5]);
      SPD_100:  h = h | (a.tx & r[2])  | (a.rx & r[3]);
      SPD_1000: h = h | (a.tx & r[0])  | (a.rx & r[1]);
      SPD_2500: h = h | (a.tx & r[10]) | (a.rx & r[11]);
    endcase
    return h & lk.up;
  endfunction

  // True when the count has reached the last tick of the period.
  function automatic logic period_done(input logic [WORD_W-1:0] cnt,
                                       input logic [WORD_W-1:0] per);
    return ({1'b0, cnt} + 17'd1) >= {1'b0, per};
  endfunction

endpackage

// File: rtl/led_regs.sv
module led_regs
  import led_pkg::*;
#(
  parameter int N_LED  = 3,
  parameter int ADDR_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [WORD_W-1:0]             wdata,
  output logic [WORD_W-1:0]             rdata,
  output logic                          ext_en,
  output logic                          run_en,
  output logic [WORD_W-1:0]             ontime_q,
  output logic [WORD_W-1:0]             period_q,
  output logic [N_LED-1:0][WORD_W-1:0]  lit_q,
  output logic [N_LED-1:0][WORD_W-1:0]  flash_q
);

  logic [WORD_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      ontime_q <= '0;
      period_q <= '0;
    end else if (wr) begin
      if (addr == ADDR_W'(A_CTRL))   ctrl_q   <= wdata & KEEP_CTRL;
      if (addr == ADDR_W'(A_ONTIME)) ontime_q <= wdata;
      if (addr == ADDR_W'(A_PERIOD)) period_q <= wdata;
    end
  end

  for (genvar i = 0; i < N_LED; i++) begin : g_rule
    localparam logic [ADDR_W-1:0] A_LIT   = ADDR_W'(A_RULE0 + 2 * i);
    localparam logic [ADDR_W-1:0] A_FLASH = ADDR_W'(A_RULE0 + 2 * i + 1);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lit_q[i]   <= '0;
        flash_q[i] <= '0;
      end else if (wr) begin
        if (addr == A_LIT)   lit_q[i]   <= wdata & KEEP_LIT;
        if (addr == A_FLASH) flash_q[i] <= wdata & KEEP_FLASH;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(A_CTRL))   rdata = ctrl_q;
    if (addr == ADDR_W'(A_ONTIME)) rdata = ontime_q;
    if (addr == ADDR_W'(A_PERIOD)) rdata = period_q;
    for (int i = 0; i < N_LED; i++) begin
      if (addr == ADDR_W'(A_RULE0 + 2 * i))     rdata = lit_q[i];
      if (addr == ADDR_W'(A_RULE0 + 2 * i + 1)) rdata = flash_q[i];
    end
  end

  assign ext_en = ctrl_q[C_EXT];
  assign run_en = ctrl_q[C_RUN];

endmodule

// File: rtl/led_tick.sv
module led_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  if (DIV <= 1) begin : g_pass
    assign tick = run;
  end else begin : g_div
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
      if (!rst_n || !run)  cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);
  end

endmodule

// File: rtl/led_chan.sv
module led_chan
  import led_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate,
  input  logic              tick,
  input  logic [WORD_W-1:0] lit_rule,
  input  logic [WORD_W-1:0] flash_rule,
  input  logic [WORD_W-1:0] ontime,
  input  logic [WORD_W-1:0] period,
  input  link_t             lk,
  input  act_t              act,
  output logic              lit,
  output logic              led_o
);

  logic              active;
  logic [WORD_W-1:0] cnt;
  logic              pend;
  logic              live, evt, req_evt, req, steady, blink_on;
  logic              unused_bits;

  assign unused_bits = ^{lit_rule[13:9], lit_rule[7], flash_rule[15:12]};

  assign live     = gate & lit_rule[L_EN];
  assign evt      = flash_match(flash_rule, lk, act);
  assign req_evt  = pend | evt;
  assign req      = req_evt | flash_rule[F_FORCE];
  assign steady   = lit_rule[L_FORCE] | lit_match(lit_rule, lk);
  assign blink_on = active && (cnt < ontime);
  assign lit      = live & (steady | blink_on);

  always_ff @(posedge clk) begin
    if (!rst_n || !live) begin
      active <= 1'b0;
      cnt    <= '0;
      pend   <= 1'b0;
    end else if (tick) begin
      if (!active) begin
        active <= req;
        cnt    <= '0;
        pend   <= 1'b0;
      end else if (period_done(cnt, period)) begin
        active <= req;
        cnt    <= '0;
        pend   <= 1'b0;
      end else begin
        cnt  <= cnt + 1'b1;
        pend <= req_evt;
      end
    end else begin
      pend <= req_evt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) led_o <= 1'b1;
    else        led_o <= lit_rule[L_POL] ? lit : ~lit;
  end

endmodule

// File: rtl/led_ctrl.sv
module led_ctrl
  import led_pkg::*;
#(
  parameter int N_LED    = 3,
  parameter int TICK_DIV = 4,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              link_up,
  input  logic [1:0]        link_speed,
  input  logic              link_fdx,
  input  logic              tx_pkt,
  input  logic              rx_pkt,
  input  logic              col_evt,
  input  logic              crc_err,
  input  logic              idle_err,
  output logic [N_LED-1:0]  led_out
);

  logic                         ext_en, run_en, gate_on, tick;
  logic [WORD_W-1:0]            ontime_q, period_q;
  logic [N_LED-1:0][WORD_W-1:0] lit_q, flash_q;
  logic [N_LED-1:0]             pol_vec, en_vec, fon_vec, lit_vec;
  link_t                        lk;
  act_t                         act;

  assign lk  = '{up: link_up, spd: speed_e'(link_speed), fdx: link_fdx};
  assign act = '{tx: tx_pkt, rx: rx_pkt, col: col_evt, crc: crc_err, idle: idle_err};

  led_regs #(.N_LED(N_LED), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .ext_en(ext_en), .run_en(run_en), .ontime_q(ontime_q),
    .period_q(period_q), .lit_q(lit_q), .flash_q(flash_q)
  );

  assign gate_on = ext_en & run_en;

  led_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run_en), .tick(tick)
  );

  for (genvar i = 0; i < N_LED; i++) begin : g_led
    assign pol_vec[i] = lit_q[i][L_POL];
    assign en_vec[i]  = lit_q[i][L_EN];
    assign fon_vec[i] = lit_q[i][L_FORCE];

    led_chan u_chan (
      .clk(clk), .rst_n(rst_n), .gate(gate_on), .tick(tick),
      .lit_rule(lit_q[i]), .flash_rule(flash_q[i]), .ontime(ontime_q),
      .period(period_q), .lk(lk), .act(act), .lit(lit_vec[i]), .led_o(led_out[i])
    );
  end

endmodule

// File: rtl/led_ctrl_chk.sv
module led_ctrl_chk #(
  parameter int N_LED    = 3,
  parameter int TICK_DIV = 4,
  parameter int ADDR_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [15:0]       reg_wdata,
  input logic              gate_on,
  input logic              tick,
  input logic [15:0]       period_q,
  input logic [N_LED-1:0]  pol_vec,
  input logic [N_LED-1:0]  en_vec,
  input logic [N_LED-1:0]  fon_vec,
  input logic [N_LED-1:0]  led_out
);

  // R3: with the output gate closed every LED goes to its inactive level
  a_r3_gate_off_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_on |=> led_out == ~$past(pol_vec));

  // R1: a period write lands in the period word
  a_r1_period_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'('h23)) |=> period_q == $past(reg_wdata));

  if (TICK_DIV > 1) begin : g_tick
    // R11: ticks are isolated pulses when the divider is above one
    a_r11_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
  end

  for (genvar i = 0; i < N_LED; i++) begin : g_per
    // R7: forced-on enabled LED shows its active level
    a_r7_force_on: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_on && en_vec[i] && fon_vec[i]) |=> led_out[i] == $past(pol_vec[i]));
    // R4: a disabled LED shows its inactive level
    a_r4_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !en_vec[i] |=> led_out[i] == !$past(pol_vec[i]));
  end

endmodule

bind led_ctrl led_ctrl_chk #(.N_LED(N_LED), .TICK_DIV(TICK_DIV), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .gate_on(gate_on), .tick(tick), .period_q(period_q), .pol_vec(pol_vec),
  .en_vec(en_vec), .fon_vec(fon_vec), .led_out(led_out)
);

// File: tb/led_ctrl_tb.sv
`timescale 1ns/1ps
module led_ctrl_tb;

  localparam int NL = 3;
  localparam int TDIV = 4;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [7:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic link_up = 0, link_fdx = 0;
  logic [1:0] link_speed = 0;
  logic tx_pkt = 0, rx_pkt = 0, col_evt = 0, crc_err = 0, idle_err = 0;
  logic [NL-1:0] led_out;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0, done = 0;
  string cur_req = "R2";

  always #2 clk = ~clk;

  led_ctrl #(.N_LED(NL), .TICK_DIV(TDIV), .ADDR_W(8)) u_dut (.*);

  // ---------------- behavioural model ----------------
  int m_ctrl, m_ont, m_per, m_pcnt;
  int m_lit[NL], m_fl[NL], m_cnt[NL];
  bit m_act[NL], m_pend[NL];
  bit [NL-1:0] m_led = '1, nled;
  bit tk, gate, live, lit, ev, want, onm;

  function automatic bit mdl_on(int r);
    if (!link_up) return r[3];
    if ((r[4] && link_fdx) || (r[5] && !link_fdx)) return 1;
    case (link_speed)
      0: return r[2];
      1: return r[1];
      2: return r[0];
      default: return r[8];
    endcase
  endfunction

  function automatic bit mdl_ev(int r);
    int tb, rb;
    if (!link_up) return 0;
    if ((col_evt && r[6]) || (crc_err && r[7]) || (idle_err && r[8])) return 1;
    case (link_speed)
      0: begin tb = 4; rb = 5; end
      1: begin tb = 2; rb = 3; end
      2: begin tb = 0; rb = 1; end
      default: begin tb = 10; rb = 11; end
    endcase
    return (tx_pkt && r[tb]) || (rx_pkt && r[rb]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_ont = 0; m_per = 0; m_pcnt = 0; m_led = '1;
      for (int i = 0; i < NL; i++) begin
        m_lit[i] = 0; m_fl[i] = 0; m_cnt[i] = 0; m_act[i] = 0; m_pend[i] = 0;
      end
    end else begin
      gate = m_ctrl[15] && m_ctrl[3];
      tk = m_ctrl[3] && (m_pcnt == TDIV - 1);
      for (int i = 0; i < NL; i++) begin
        live = gate && m_lit[i][15];
        onm = m_lit[i][6] || mdl_on(m_lit[i]);
        lit = live && (onm || (m_act[i] && m_cnt[i] < m_ont));
        nled[i] = m_lit[i][14] ? lit : !lit;
        ev = mdl_ev(m_fl[i]);
        if (!live) begin
          m_act[i] = 0; m_cnt[i] = 0; m_pend[i] = 0;
        end else begin
          want = m_pend[i] || ev || m_fl[i][9];
          if (tk) begin
            if (!m_act[i]) begin
              m_act[i] = want; m_cnt[i] = 0; m_pend[i] = 0;
            end else if (m_cnt[i] + 1 >= m_per) begin
              m_act[i] = want; m_cnt[i] = 0; m_pend[i] = 0;
            end else begin
              m_cnt[i]++; m_pend[i] = m_pend[i] || ev;
            end
          end else m_pend[i] = m_pend[i] || ev;
        end
      end
      m_led = nled;
      if (!m_ctrl[3] || m_pcnt == TDIV - 1) m_pcnt = 0; else m_pcnt++;
      if (reg_wr) begin
        if (reg_addr == 8'h21) m_ctrl = reg_wdata & 16'h800F;
        if (reg_addr == 8'h22) m_ont = reg_wdata;
        if (reg_addr == 8'h23) m_per = reg_wdata;
        for (int i = 0; i < NL; i++) begin
          if (reg_addr == 8'(36 + 2 * i)) m_lit[i] = reg_wdata & 16'hC17F;
          if (reg_addr == 8'(37 + 2 * i)) m_fl[i] = reg_wdata & 16'h0FFF;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      n_chk++;
      if (led_out !== m_led) begin
        n_fail++;
        $display("FAIL %s model compare: led_out=%b expected %b", cur_req, led_out, m_led);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    reg_wr = 1; reg_addr = 8'(a); reg_wdata = 16'(d);
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(int a, int exp, string tag);
    reg_addr = 8'(a);
    @(negedge clk);
    chk(reg_rdata == 16'(exp), tag, reg_rdata, exp);
    @(posedge clk); #1;
  endtask

  task automatic expect_led(bit [NL-1:0] exp, string tag);
    repeat (2) @(negedge clk);
    chk(led_out == exp, tag, led_out, exp);
    @(posedge clk); #1;
  endtask

  task automatic set_link(bit up, int spd, bit fdx);
    link_up = up; link_speed = 2'(spd); link_fdx = fdx;
  endtask

  task automatic count_lit(int idx, int n, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (led_out[idx]) cnt++;
    end
    @(posedge clk); #1;
  endtask

  task automatic pulse_tx();
    tx_pkt = 1; @(posedge clk); #1; tx_pkt = 0;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int c;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(led_out == 3'b111, "R2 reset outputs", led_out, 7);
    @(posedge clk); #1;
    cmp_on = 1;
    for (int a = 'h21; a <= 'h29; a++) rd(a, 0, "R2 reset word");

    cur_req = "R1";
    wr('h24, 'hFFFF); rd('h24, 'hC17F, "R1 lit-rule mask");
    wr('h25, 'hFFFF); rd('h25, 'h0FFF, "R1 flash-rule mask");
    wr('h21, 'hFFFF); rd('h21, 'h800F, "R1 control mask");
    wr('h23, 'hABCD); rd('h23, 'hABCD, "R1 period word");
    wr('h2A, 'h1234); rd('h2A, 0, "R1 unmapped address");
    rd('h20, 0, "R1 unmapped low address");
    rd('h29, 0, "R1 last flash word untouched");

    cur_req = "R3";
    wr('h21, 0); wr('h25, 0);
    wr('h24, 'hC001); wr('h26, 'h8102); wr('h28, 'hC004);
    set_link(1, 2, 1);
    expect_led(3'b010, "R3 control zero holds inactive");
    wr('h21, 'h8000); expect_led(3'b010, "R3 clock run clear");
    wr('h21, 'h0008); expect_led(3'b010, "R3 external drive clear");

    cur_req = "R5";
    wr('h21, 'h8008);
    expect_led(3'b011, "R5 speed 1000");
    set_link(1, 1, 1); expect_led(3'b000, "R5 speed 100");
    set_link(1, 0, 1); expect_led(3'b110, "R5 speed 10");
    set_link(1, 3, 1); expect_led(3'b000, "R5 speed 2500");
    set_link(0, 3, 1); expect_led(3'b010, "R5 link down");

    cur_req = "R6";
    wr('h24, 'hC010); wr('h26, 'hC020); wr('h28, 'hC008);
    set_link(1, 2, 1); expect_led(3'b001, "R6 full duplex");
    set_link(1, 2, 0); expect_led(3'b010, "R6 half duplex");
    set_link(0, 2, 1); expect_led(3'b100, "R6 link down");

    cur_req = "R7";
    wr('h24, 'hC040); wr('h26, 'h8040); wr('h28, 'h4040);
    expect_led(3'b001, "R7 force on with polarity");
    cur_req = "R12";
    wr('h21, 'h800F); rd('h21, 'h800F, "R12 mode bits stored");
    expect_led(3'b001, "R12 mode bits no effect");
    cur_req = "R4";
    wr('h28, 'h0040); expect_led(3'b101, "R4 disabled polarity zero");
    wr('h24, 'h8040); expect_led(3'b100, "R4 polarity zero inverts");

    cur_req = "R8";
    wr('h21, 'h8008); wr('h22, 2); wr('h23, 4);
    wr('h24, 'hC000); wr('h26, 'hC000); wr('h28, 'hC000);
    wr('h25, 'h0003); wr('h27, 'h0040); wr('h29, 'h0400);
    set_link(1, 2, 1);
    repeat (5) @(posedge clk); #1;
    pulse_tx();
    count_lit(0, 40, c);
    chk(c == 2 * TDIV, "R9 single event lit length", c, 2 * TDIV);
    chk(c == 2 * TDIV, "R11 tick spacing", c, 2 * TDIV);
    chk(led_out[2] == 0, "R8 wrong speed ignored", led_out[2], 0);
    col_evt = 1; @(posedge clk); #1; col_evt = 0;
    count_lit(1, 40, c);
    chk(c == 2 * TDIV, "R8 collision event", c, 2 * TDIV);
    set_link(0, 2, 1);
    pulse_tx();
    count_lit(0, 40, c);
    chk(c == 0, "R8 link down no event", c, 0);

    cur_req = "R9";
    set_link(1, 2, 1);
    for (int k = 0; k < 8; k++) begin
      pulse_tx(); repeat (9) @(posedge clk); #1;
    end
    count_lit(0, 60, c);
    chk(c == 2 * TDIV, "R9 rearm ends after last event", c, 2 * TDIV);

    cur_req = "R10";
    wr('h22, 1); wr('h23, 3); wr('h29, 'h0200);
    count_lit(2, 96, c);
    chk(c >= 28 && c <= 36, "R10 force flash duty", c, 32);
    wr('h23, 0);
    repeat (10) @(posedge clk); #1;
    count_lit(2, 20, c);
    chk(c == 20, "R9 zero period wrap", c, 20);

    cur_req = "R11";
    wr('h21, 'h8000);
    expect_led(3'b000, "R11 clock run clear idles");
    wr('h21, 'h8008); wr('h23, 4); wr('h22, 2);
    repeat (40) @(posedge clk); #1;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule